// File: doc/BRIEF.md
# Radio Frame Transmit Sequencer

This block runs the transmit side of a packet radio for one frame at a time. A host loads the frame into a byte-wide frame store through a simple write port. It starts the frame either with a strobe pin or with a command written to a state register. The two actions may come in either order. When the start comes first, the host keeps filling the store while the radio is still settling and sending its preamble.

Once a start is accepted, the block counts microsecond ticks through a fixed settle-and-header window. No frame store byte is used during that window. At the end of the window the block sends the length byte. It then sends the payload bytes at a fixed number of ticks per byte. If a byte is needed that the host has not yet written, the frame is abandoned and an underrun is reported. A completed frame raises an end-of-frame event instead. Both events are latched in a status register. A single interrupt line stays high until that register is read.

Top module: `trx_tx_seq`

## Requirements
- R1: A frame is started by a rising edge on `tx_strobe`, or by writing the value 0x02 to register address 0x02.
- R2: After reset the radio state reads 0x08 (off) at address 0x02. Writing 0x09 selects the ready state and 0x19 selects the retry-ready state. A start is accepted only in state 0x09 or 0x19. Once accepted, the state reads 0x02 (busy). A start in any other state, including while busy, is ignored.
- R3: After acceptance, no byte is output until SETTLE_TICKS+HDR_TICKS ticks (default 16+160) have passed. The length byte is output on that last tick.
- R4: The low 7 bits of the length byte give the payload length L; bit 7 is ignored. Exactly L payload bytes follow, one every BYTE_TICKS ticks (default 32), in the order they were written. Each output byte is marked by a one-cycle `tx_byte_valid` pulse.
- R5: If a byte is due and the host has not written it yet (write count not greater than its index), the block sets bit 6 of the status register. It outputs nothing more for that frame and returns to state 0x09.
- R6: After the last byte goes out (the length byte itself when L is 0), the block sets bit 3 of the status register. It then returns to the ready state from which the frame was started.
- R7: `irq` is high while any status bit is pending. Reading address 0x0F returns the pending bits and clears them. A read of any other address returns 0.
- R8: When a status read falls in the same cycle as a new event, that new event stays pending.
- R9: Asserting `fb_wr_first` writes the byte to index 0 and restarts the write count at 1. Writes made during a frame become available to it. A write in the same cycle that its byte is needed is too late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse each microsecond |
| tx_strobe | input | 1 | Start strobe; the rising edge requests a frame |
| fb_wr_en | input | 1 | Frame store write enable |
| fb_wr_first | input | 1 | Current write is byte 0 of a new frame |
| fb_wr_data | input | 8 | Frame store write data |
| reg_wr_en | input | 1 | Register write enable |
| reg_rd_en | input | 1 | Register read enable (a read of 0x0F clears status) |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt, high while a status bit is pending |
| tx_byte_valid | output | 1 | Pulse marking a byte handed to the modulator |
| tx_byte | output | 8 | Byte handed to the modulator |

## Verification
The hardest case to reach is a status read that lands in exactly the cycle of a new event. The bench holds the read enable on address 0x0F for the whole of a short frame, so the end event is certain to coincide with a read. Late-arriving data is handled in a similar way: the bench starts frames before writing them and feeds bytes during the header window or too slowly. This drives underrun both at the length byte and in mid-payload. A behavioural model predicts every output on every clock, so a same-cycle write racing a byte that is due is checked wherever it happens.

// File: rtl/trx_tx_pkg.sv
package trx_tx_pkg;

  typedef enum logic [4:0] {
    RS_BUSY_TX = 5'h02,
    RS_TRX_OFF = 5'h08,
    RS_PLL_ON  = 5'h09,
    RS_ARET_ON = 5'h19
  } radio_state_t;

  localparam logic [7:0] CMD_TX_START = 8'h02;
  localparam logic [7:0] CMD_TRX_OFF  = 8'h08;
  localparam logic [7:0] CMD_PLL_ON   = 8'h09;
  localparam logic [7:0] CMD_ARET_ON  = 8'h19;

  localparam logic [5:0] ADDR_STATE = 6'h02;
  localparam logic [5:0] ADDR_IRQ   = 6'h0F;

  localparam int IRQ_BIT_END = 3;
  localparam int IRQ_BIT_UR  = 6;

  // Frame length carried by the length byte (top bit ignored).
  function automatic logic [6:0] phr_length(input logic [7:0] b);
    return 7'(b & 8'h7F);
  endfunction

  // Transmit-ready states that accept a start request.
  function automatic logic is_ready(input radio_state_t s);
    return (s == RS_PLL_ON) || (s == RS_ARET_ON);
  endfunction

  // A byte index is available when the host has written past it.
  function automatic logic byte_present(input int wr_count, input int idx);
    return wr_count > idx;
  endfunction

  // True when the payload byte at idx is the final one of the frame.
  function automatic logic is_last_payload(input int idx, input int len);
    return idx == len;
  endfunction

endpackage

// File: rtl/trx_fb_store.sv
module trx_fb_store #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_first,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [ADDR_W:0]   wr_cnt
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  // Write pointer; restarts on the first byte of a new frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt <= '0;
    end else if (wr_en) begin
      if (wr_first) begin
        wr_cnt <= (ADDR_W+1)'(1);
      end else if (wr_cnt < (ADDR_W+1)'(DEPTH)) begin
        wr_cnt <= wr_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wr_first) begin
        mem[0] <= wr_data;
      end else if (wr_cnt < (ADDR_W+1)'(DEPTH)) begin
        mem[wr_cnt[ADDR_W-1:0]] <= wr_data;
      end
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/trx_host_regs.sv
module trx_host_regs
  import trx_tx_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_strobe,
  input  logic         reg_wr_en,
  input  logic         reg_rd_en,
  input  logic [5:0]   reg_addr,
  input  logic [7:0]   reg_wdata,
  input  radio_state_t state,
  input  logic         ev_end,
  input  logic         ev_ur,
  output logic         start_req,
  output logic         cmd_valid,
  output logic [7:0]   cmd_code,
  output logic         stat_rd,
  output logic [7:0]   reg_rdata,
  output logic         irq
);
  logic       strobe_q;
  logic [7:0] pending_q;
  logic [7:0] new_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= tx_strobe;
  end

  always_comb begin
    cmd_valid = reg_wr_en && (reg_addr == ADDR_STATE);
    cmd_code  = reg_wdata;
    start_req = (tx_strobe && !strobe_q) || (cmd_valid && (reg_wdata == CMD_TX_START));
    stat_rd   = reg_rd_en && (reg_addr == ADDR_IRQ);
    new_ev    = '0;
    new_ev[IRQ_BIT_END] = ev_end;
    new_ev[IRQ_BIT_UR]  = ev_ur;
  end

  // A read clears what was pending before; events of this cycle survive.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= '0;
    else        pending_q <= (stat_rd ? 8'h00 : pending_q) | new_ev;
  end

  always_comb begin
    case (reg_addr)
      ADDR_IRQ:   reg_rdata = pending_q;
      ADDR_STATE: reg_rdata = {3'b000, state};
      default:    reg_rdata = 8'h00;
    endcase
  end

  assign irq = |pending_q;

endmodule

// File: rtl/trx_tx_fsm.sv
module trx_tx_fsm
  import trx_tx_pkg::*;
#(
  parameter int ADDR_W       = 7,
  parameter int SETTLE_TICKS = 16,
  parameter int HDR_TICKS    = 160,
  parameter int BYTE_TICKS   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              start_req,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [ADDR_W:0]   wr_cnt,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output radio_state_t      state,
  output logic              accept,
  output logic              hdr_phase,
  output logic              ev_end,
  output logic              ev_ur,
  output logic              tx_byte_valid,
  output logic [7:0]        tx_byte
);
  localparam int WIN_TICKS = SETTLE_TICKS + HDR_TICKS;
  localparam int CNT_MAX   = (WIN_TICKS > BYTE_TICKS) ? WIN_TICKS : BYTE_TICKS;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  radio_state_t    state_q, origin_q;
  logic            hdr_q;
  logic [CNT_W-1:0] cnt_q, lim;
  logic [ADDR_W:0] idx_q;
  logic [6:0]      len_q;
  logic            cnt_last, need, have, emit, last;

  always_comb begin
    lim      = hdr_q ? CNT_W'(WIN_TICKS - 1) : CNT_W'(BYTE_TICKS - 1);
    cnt_last = tick_us && (cnt_q == lim);
    need     = (state_q == RS_BUSY_TX) && cnt_last;
    have     = byte_present(int'(wr_cnt), int'(idx_q));
    emit     = need && have;
    last     = hdr_q ? (phr_length(rd_data) == 7'd0)
                     : is_last_payload(int'(idx_q), int'(len_q));
    ev_ur    = need && !have;
    ev_end   = emit && last;
    accept   = start_req && is_ready(state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= RS_TRX_OFF;
      origin_q      <= RS_PLL_ON;
      hdr_q         <= 1'b0;
      cnt_q         <= '0;
      idx_q         <= '0;
      len_q         <= '0;
      tx_byte_valid <= 1'b0;
      tx_byte       <= '0;
    end else begin
      tx_byte_valid <= 1'b0;
      if (accept) begin
        state_q  <= RS_BUSY_TX;
        origin_q <= state_q;
        hdr_q    <= 1'b1;
        cnt_q    <= '0;
        idx_q    <= '0;
      end else if (state_q == RS_BUSY_TX) begin
        if (tick_us) begin
          cnt_q <= cnt_last ? '0 : cnt_q + 1'b1;
        end
        if (ev_ur) begin
          state_q <= RS_PLL_ON;
        end
        if (emit) begin
          tx_byte_valid <= 1'b1;
          tx_byte       <= rd_data;
          idx_q         <= idx_q + 1'b1;
          if (hdr_q) begin
            len_q <= phr_length(rd_data);
            hdr_q <= 1'b0;
          end
          if (last) begin
            state_q <= origin_q;
          end
        end
      end else if (cmd_valid) begin
        case (cmd_code)
          CMD_PLL_ON:  state_q <= RS_PLL_ON;
          CMD_ARET_ON: state_q <= RS_ARET_ON;
          CMD_TRX_OFF: state_q <= RS_TRX_OFF;
          default:     state_q <= state_q;
        endcase
      end
    end
  end

  assign rd_addr   = idx_q[ADDR_W-1:0];
  assign state     = state_q;
  assign hdr_phase = hdr_q;

endmodule

// File: rtl/trx_tx_seq.sv
module trx_tx_seq
  import trx_tx_pkg::*;
#(
  parameter int ADDR_W       = 7,
  parameter int SETTLE_TICKS = 16,
  parameter int HDR_TICKS    = 160,
  parameter int BYTE_TICKS   = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_us,
  input  logic       tx_strobe,
  input  logic       fb_wr_en,
  input  logic       fb_wr_first,
  input  logic [7:0] fb_wr_data,
  input  logic       reg_wr_en,
  input  logic       reg_rd_en,
  input  logic [5:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       tx_byte_valid,
  output logic [7:0] tx_byte
);
  // Named internal events, brought out for the checker.
  radio_state_t      state_w;
  logic              start_req_w, cmd_valid_w, stat_rd_w;
  logic [7:0]        cmd_code_w;
  logic              accept_w, hdr_w, ev_end_w, ev_ur_w;
  logic [ADDR_W:0]   wr_cnt_w;
  logic [ADDR_W-1:0] rd_addr_w;
  logic [7:0]        rd_data_w;

  trx_fb_store #(.ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (fb_wr_en),
    .wr_first (fb_wr_first),
    .wr_data  (fb_wr_data),
    .rd_addr  (rd_addr_w),
    .rd_data  (rd_data_w),
    .wr_cnt   (wr_cnt_w)
  );

  trx_host_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_strobe (tx_strobe),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .state     (state_w),
    .ev_end    (ev_end_w),
    .ev_ur     (ev_ur_w),
    .start_req (start_req_w),
    .cmd_valid (cmd_valid_w),
    .cmd_code  (cmd_code_w),
    .stat_rd   (stat_rd_w),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  trx_tx_fsm #(
    .ADDR_W       (ADDR_W),
    .SETTLE_TICKS (SETTLE_TICKS),
    .HDR_TICKS    (HDR_TICKS),
    .BYTE_TICKS   (BYTE_TICKS)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_us       (tick_us),
    .start_req     (start_req_w),
    .cmd_valid     (cmd_valid_w),
    .cmd_code      (cmd_code_w),
    .wr_cnt        (wr_cnt_w),
    .rd_data       (rd_data_w),
    .rd_addr       (rd_addr_w),
    .state         (state_w),
    .accept        (accept_w),
    .hdr_phase     (hdr_w),
    .ev_end        (ev_end_w),
    .ev_ur         (ev_ur_w),
    .tx_byte_valid (tx_byte_valid),
    .tx_byte       (tx_byte)
  );

endmodule

// File: rtl/trx_tx_seq_chk.sv
module trx_tx_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] state,
  input logic       accept,
  input logic       hdr_phase,
  input logic       ev_end,
  input logic       ev_ur,
  input logic       stat_rd,
  input logic       irq,
  input logic       tx_byte_valid
);
  a_r2_accept_only_ready: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (state == 5'h09 || state == 5'h19));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state == 5'h02));

  a_r3_quiet_header: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 5'h02 && hdr_phase) |-> !tx_byte_valid);

  a_r5_underrun_to_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ur |=> (state == 5'h09 && !tx_byte_valid && irq));

  a_r5_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_end, ev_ur}));

  a_r6_end_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> (irq && tx_byte_valid && state != 5'h02));

  a_r7_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !stat_rd) |=> irq);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ev_end && !ev_ur) |=> !irq);

  a_r8_keep_new_event: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && (ev_end || ev_ur)) |=> irq);

endmodule

bind trx_tx_seq trx_tx_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .state         (state_w),
  .accept        (accept_w),
  .hdr_phase     (hdr_w),
  .ev_end        (ev_end_w),
  .ev_ur         (ev_ur_w),
  .stat_rd       (stat_rd_w),
  .irq           (irq),
  .tx_byte_valid (tx_byte_valid)
);

// File: tb/tb_trx_tx_seq.sv
module tb_trx_tx_seq;
  localparam int CLK_P  = 10;
  localparam int WIN    = 176;
  localparam int BYTE_T = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b0;
  logic tx_strobe = 1'b0;
  logic fb_wr_en = 1'b0, fb_wr_first = 1'b0;
  logic [7:0] fb_wr_data = '0;
  logic reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, tx_byte_valid;
  logic [7:0] tx_byte;

  int total = 0, bad = 0;

  trx_tx_seq #(.ADDR_W(7), .SETTLE_TICKS(16), .HDR_TICKS(160), .BYTE_TICKS(BYTE_T)) dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .tx_strobe(tx_strobe),
    .fb_wr_en(fb_wr_en), .fb_wr_first(fb_wr_first), .fb_wr_data(fb_wr_data),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .tx_byte_valid(tx_byte_valid), .tx_byte(tx_byte));

  always #(CLK_P/2) clk = ~clk;
  always @(negedge clk) tick_us <= ~tick_us;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int fbq[$];
  int m_state = 8, m_origin = 9, m_cnt = 0, m_idx = 0, m_len = 0, m_pend = 0, m_byte = 0;
  bit m_hdr = 0, m_valid = 0, m_slpq = 0;
  int tk_since = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      fbq = {}; m_state = 8; m_cnt = 0; m_idx = 0; m_pend = 0; m_valid = 0;
      m_slpq = 0; m_hdr = 0;
    end else begin
      bit start, stat, ev_e, ev_u, vld;
      int lim;
      start = (tx_strobe && !m_slpq) || (reg_wr_en && reg_addr == 6'h02 && reg_wdata == 8'h02);
      stat = reg_rd_en && reg_addr == 6'h0F;
      ev_e = 0; ev_u = 0; vld = 0;
      if (tx_strobe && !m_slpq) tk_since = 0;
      else if (tick_us) tk_since++;
      if (start && (m_state == 9 || m_state == 25)) begin
        m_origin = m_state; m_state = 2; m_hdr = 1; m_cnt = 0; m_idx = 0;
      end else if (m_state == 2) begin
        if (tick_us) begin
          lim = m_hdr ? WIN : BYTE_T;
          if (m_cnt + 1 == lim) begin
            m_cnt = 0;
            if (fbq.size() > m_idx) begin
              bit fin;
              vld = 1; m_byte = fbq[m_idx];
              if (m_hdr) begin
                m_len = m_byte % 128; m_hdr = 0; fin = (m_len == 0);
              end else fin = (m_idx == m_len);
              m_idx++;
              if (fin) begin ev_e = 1; m_state = m_origin; end
            end else begin
              ev_u = 1; m_state = 9;
            end
          end else m_cnt++;
        end
      end else if (reg_wr_en && reg_addr == 6'h02) begin
        if (reg_wdata == 8'h09) m_state = 9;
        else if (reg_wdata == 8'h19) m_state = 25;
        else if (reg_wdata == 8'h08) m_state = 8;
      end
      if (fb_wr_en) begin
        if (fb_wr_first) fbq = {int'(fb_wr_data)};
        else if (fbq.size() < 128) fbq.push_back(int'(fb_wr_data));
      end
      m_pend = (stat ? 0 : m_pend) | (ev_u ? 64 : 0) | (ev_e ? 8 : 0);
      m_valid = vld;
      m_slpq = tx_strobe;
    end
  end

  // Per-clock comparison, away from the edge
  int n_bytes = 0, tk_at_phr = -1;
  bit seen_irq = 0;
  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (rst_n) begin
      int exp_rd;
      exp_rd = (reg_addr == 6'h0F) ? m_pend : (reg_addr == 6'h02) ? m_state : 0;
      check(irq == (m_pend != 0), "R7 irq per-cycle", irq, m_pend != 0);
      check(tx_byte_valid == m_valid, "R4 valid per-cycle", tx_byte_valid, m_valid);
      if (m_valid) check(tx_byte == m_byte[7:0], "R4 byte per-cycle", tx_byte, m_byte);
      check(reg_rdata == exp_rd[7:0], "R2 rdata per-cycle", reg_rdata, exp_rd);
      if (tx_byte_valid) begin
        if (n_bytes == 0) tk_at_phr = tk_since;
        n_bytes++;
      end
      if (irq) seen_irq = 1;
    end
  end

  task automatic wr_cmd(input logic [7:0] c);
    @(negedge clk); reg_wr_en = 1; reg_addr = 6'h02; reg_wdata = c;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic fb_put(input logic [7:0] d, input bit first);
    @(negedge clk); fb_wr_en = 1; fb_wr_first = first; fb_wr_data = d;
    @(negedge clk); fb_wr_en = 0; fb_wr_first = 0;
  endtask

  task automatic strobe();
    @(negedge clk); tx_strobe = 1;
    @(negedge clk); tx_strobe = 0;
  endtask

  task automatic rd_reg(input logic [5:0] a, output int v);
    @(negedge clk); reg_rd_en = 1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk); reg_rd_en = 0; reg_addr = 6'h00;
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (m_state == 2) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic fresh();
    n_bytes = 0; tk_at_phr = -1; seen_irq = 0;
  endtask

  int v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(irq == 0, "R7 reset irq", irq, 0);
    check(tx_byte_valid == 0, "R4 reset valid", tx_byte_valid, 0);
    rd_reg(6'h02, v); check(v == 8'h08, "R2 reset state", v, 8'h08);

    // Start in off state is ignored
    fresh(); strobe(); repeat (400) @(negedge clk);
    rd_reg(6'h02, v); check(v == 8'h08, "R2 start ignored off", v, 8'h08);
    check(n_bytes == 0, "R2 no bytes when off", n_bytes, 0);

    // Underrun at the length byte: nothing written since reset
    wr_cmd(8'h09);
    rd_reg(6'h02, v); check(v == 8'h09, "R2 ready state", v, 8'h09);
    fresh(); strobe(); wait_idle();
    check(n_bytes == 0, "R5 no output on underrun", n_bytes, 0);
    rd_reg(6'h0F, v); check(v == 8'h40, "R5 underrun status", v, 8'h40);
    rd_reg(6'h02, v); check(v == 8'h09, "R5 back to ready", v, 8'h09);

    // Buffer first, then strobe: full frame
    fb_put(8'h05, 1);
    for (int i = 0; i < 5; i++) fb_put(8'hA0 + 8'(i), 0);
    fresh(); strobe(); wait_idle();
    check(n_bytes == 6, "R4 byte count", n_bytes, 6);
    check(tk_at_phr == WIN, "R3 header window ticks", tk_at_phr, WIN);
    check(irq == 1, "R6 irq after end", irq, 1);
    rd_reg(6'h0F, v); check(v == 8'h08, "R6 end status", v, 8'h08);
    @(negedge clk); check(irq == 0, "R7 read clears irq", irq, 0);
    rd_reg(6'h0F, v); check(v == 8'h00, "R7 status empty", v, 0);

    // Second start while busy is ignored
    fb_put(8'h03, 1);
    for (int i = 0; i < 3; i++) fb_put(8'h30 + 8'(i), 0);
    fresh(); strobe(); repeat (60) @(negedge clk);
    strobe(); wr_cmd(8'h02); wait_idle();
    check(n_bytes == 4, "R2 restart ignored while busy", n_bytes, 4);
    rd_reg(6'h0F, v); check(v == 8'h08, "R6 end status 2", v, 8'h08);

    // Retry-ready state, command start before the frame is written
    wr_cmd(8'h19);
    fresh(); wr_cmd(8'h02);
    fb_put(8'h84, 1);
    for (int i = 0; i < 4; i++) begin
      repeat (20) @(negedge clk);
      fb_put(8'h50 + 8'(i), 0);
    end
    wait_idle();
    check(n_bytes == 5, "R9 writes during header", n_bytes, 5);
    check(n_bytes == 5, "R1 command start", n_bytes, 5);
    rd_reg(6'h02, v); check(v == 8'h19, "R6 return to origin", v, 8'h19);
    rd_reg(6'h0F, v); check(v == 8'h08, "R6 end status 3", v, 8'h08);

    // Mid-payload underrun from the retry-ready state
    fb_put(8'h06, 1); fb_put(8'h11, 0); fb_put(8'h22, 0);
    fresh(); strobe(); wait_idle();
    check(n_bytes == 3, "R5 partial frame", n_bytes, 3);
    rd_reg(6'h0F, v); check(v == 8'h40, "R5 mid underrun status", v, 8'h40);
    rd_reg(6'h02, v); check(v == 8'h09, "R5 to ready after retry", v, 8'h09);

    // Zero-length frame
    fb_put(8'h80, 1);
    fresh(); strobe(); wait_idle();
    check(n_bytes == 1, "R4 length byte only", n_bytes, 1);
    rd_reg(6'h0F, v); check(v == 8'h08, "R6 end on zero length", v, 8'h08);

    // Status read held across the end event
    fb_put(8'h01, 1); fb_put(8'h77, 0);
    fresh(); strobe();
    @(negedge clk); reg_rd_en = 1; reg_addr = 6'h0F;
    while (m_state == 2) @(negedge clk);
    repeat (3) @(negedge clk);
    reg_rd_en = 0; reg_addr = 6'h00;
    check(seen_irq == 1, "R8 event kept on coincident read", seen_irq, 1);
    @(negedge clk); check(irq == 0, "R8 later read clears", irq, 0);
    check(n_bytes == 2, "R4 one-byte payload", n_bytes, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule